// File: doc/BRIEF.md
# Audio Sampling Speed Mode Detector

This block decides which sampling speed class an audio converter runs in. It can do this in two ways. In automatic mode it measures how many master clock cycles fall in one frame clock period and matches that count against three nominal ratios: 512, 256 and 128 cycles per frame. In manual mode it takes the speed from a two-bit field that a control register supplies.

Outputs in the automatic mode change only after the same class has been measured on two frames in a row. A frame whose length fits no class drops the lock flag and keeps the last speed code. The converter's sigma-delta clock dividers and filters use the speed code. The ADC enable qualifier is low whenever the converter runs at quad speed, because the recording path has no quad-speed mode. The frame clock runs on a separate clock, so it is brought into the master clock domain through a two-flop synchroniser before its edges are counted.

Top module: `spd_mode_detect`

## Requirements
- R1: In automatic mode (autoMode=1), frames of 512 master clocks give speedCode 2'b00 (normal) with lockValid high.
- R2: In automatic mode, frames of 256 master clocks give speedCode 2'b01 (double) with lockValid high.
- R3: In automatic mode, frames of 128 master clocks give speedCode 2'b10 (quad) with lockValid high. This covers 176.4 kHz and 192 kHz frame rates with a 128fs master clock.
- R4: A frame length within 4 cycles of a nominal ratio is accepted as that ratio. A frame length 5 or more cycles away from every nominal ratio is rejected.
- R5: speedCode changes in automatic mode only after two consecutive measured frames give the same new class. After a single frame of a different class, the old code stays and lockValid is low.
- R6: A measured frame that matches no ratio drives lockValid low and leaves speedCode unchanged. The same happens when the frame clock stops for 4095 master clocks.
- R7: In manual mode (autoMode=0), dfsBits 2'b00, 2'b01 and 2'b10 appear on speedCode one clock later, with lockValid high. dfsBits 2'b11 drives lockValid low and holds speedCode.
- R8: adcEnable is high only while lockValid is high and speedCode is not 2'b10 (quad).
- R9: After reset, speedCode is 2'b00, lockValid is low and adcEnable is low.
- R10: On entry into automatic mode, lockValid drops on the next clock and stays low until two new frames agree. The first frame boundary after entry only starts a measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; every register runs on it |
| rstN | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Frame clock, asynchronous to mclk |
| autoMode | input | 1 | 1 = measure the ratio, 0 = take dfsBits |
| dfsBits | input | 2 | Manual speed field |
| speedCode | output | 2 | 00 normal, 01 double, 10 quad |
| lockValid | output | 1 | Speed code is confirmed and current |
| adcEnable | output | 1 | Recording path may run at this speed |

## Verification
The bench changes the frame length step by step: between ratios, to the edges of the acceptance window (plus or minus 4 accepted, plus 5 rejected), and to a length between ratios. A detector that updates on a single frame would show the new code one frame early. A window that is one cycle off would either lose lock at 516 or 508, or lock at 517. Stopping the frame clock shows whether a missing edge leaves a stale lock in place. Manual mode is checked for every field value, including the reserved one, which must hold the code rather than show it as a speed. Re-entry into automatic mode must drop lock instead of trusting a count that started while the block was in manual mode.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } speed_e;

  // Measurement events reported by the datapath, one-cycle strobes.
  typedef struct packed {
    logic   measDone;
    logic   hit;
    speed_e cls;
    logic   stall;
  } meas_evt_t;

  // Commands from the control to the datapath.
  typedef struct packed {
    logic rearm;
  } ctrl_cmd_t;

endpackage

// File: rtl/spd_meas_path.sv
module spd_meas_path
  import spd_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int BASE_RATIO = 512,
  parameter int TOL        = 4,
  parameter int SPEED_N    = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lrck,
  input  ctrl_cmd_t cmd,
  output meas_evt_t evt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_PRE = {{(CNT_W-1){1'b1}}, 1'b0};

  logic             syncA, syncB, syncC;
  logic             riseSeen;
  logic [CNT_W-1:0] cnt;
  logic             primed;
  logic [SPEED_N-1:0] hitVec;
  logic             anyHit;
  speed_e           clsNow;

  assign riseSeen = syncB & ~syncC;

  // One acceptance window per speed class; nominal ratio halves per step.
  for (genvar g = 0; g < SPEED_N; g++) begin : g_win
    localparam int NOM = BASE_RATIO >> g;
    localparam int LO  = NOM - TOL;
    localparam int HI  = NOM + TOL;
    assign hitVec[g] = (int'(cnt) >= LO) && (int'(cnt) <= HI);
  end

  always_comb begin
    clsNow = SPD_NORMAL;
    for (int i = SPEED_N - 1; i >= 0; i--) begin
      if (hitVec[i]) clsNow = speed_e'(i[1:0]);
    end
    anyHit = |hitVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= 1'b0;
      syncB  <= 1'b0;
      syncC  <= 1'b0;
      cnt    <= '0;
      primed <= 1'b0;
      evt    <= '0;
    end else begin
      syncA        <= lrck;
      syncB        <= syncA;
      syncC        <= syncB;
      evt.measDone <= 1'b0;
      evt.stall    <= 1'b0;
      if (riseSeen) begin
        cnt    <= {{(CNT_W-1){1'b0}}, 1'b1};
        primed <= ~cmd.rearm;
        if (primed && !cmd.rearm) begin
          evt.measDone <= 1'b1;
          evt.hit      <= anyHit;
          evt.cls      <= clsNow;
        end
      end else begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (cnt == CNT_PRE) evt.stall <= 1'b1;
        if (cmd.rearm) primed <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spd_ctrl.sv
module spd_ctrl
  import spd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       autoMode,
  input  logic [1:0] dfsBits,
  input  meas_evt_t  evt,
  output ctrl_cmd_t  cmd,
  output speed_e     speedCode,
  output logic       lockValid
);

  logic   autoQ;
  logic   candValid;
  speed_e cand;

  assign cmd.rearm = autoMode & ~autoQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoQ     <= 1'b0;
      speedCode <= SPD_NORMAL;
      lockValid <= 1'b0;
      candValid <= 1'b0;
      cand      <= SPD_NORMAL;
    end else begin
      autoQ <= autoMode;
      if (!autoMode) begin
        candValid <= 1'b0;
        if (dfsBits != SPD_RSVD) begin
          speedCode <= speed_e'(dfsBits);
          lockValid <= 1'b1;
        end else begin
          lockValid <= 1'b0;
        end
      end else if (!autoQ) begin
        lockValid <= 1'b0;
        candValid <= 1'b0;
      end else if (evt.stall) begin
        lockValid <= 1'b0;
        candValid <= 1'b0;
      end else if (evt.measDone) begin
        if (!evt.hit) begin
          lockValid <= 1'b0;
          candValid <= 1'b0;
        end else if (candValid && evt.cls == cand) begin
          speedCode <= evt.cls;
          lockValid <= 1'b1;
        end else begin
          cand      <= evt.cls;
          candValid <= 1'b1;
          if (evt.cls != speedCode) lockValid <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/spd_mode_detect.sv
module spd_mode_detect
  import spd_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int BASE_RATIO = 512,
  parameter int TOL        = 4
) (
  input  logic       mclk,
  input  logic       rstN,
  input  logic       lrck,
  input  logic       autoMode,
  input  logic [1:0] dfsBits,
  output logic [1:0] speedCode,
  output logic       lockValid,
  output logic       adcEnable
);

  meas_evt_t evt;
  ctrl_cmd_t cmd;
  speed_e    code;

  spd_meas_path #(
    .CNT_W(CNT_W), .BASE_RATIO(BASE_RATIO), .TOL(TOL), .SPEED_N(3)
  ) u_path (
    .clk(mclk), .rstN(rstN), .lrck(lrck), .cmd(cmd), .evt(evt)
  );

  spd_ctrl u_ctrl (
    .clk(mclk), .rstN(rstN), .autoMode(autoMode), .dfsBits(dfsBits),
    .evt(evt), .cmd(cmd), .speedCode(code), .lockValid(lockValid)
  );

  assign speedCode = code;
  assign adcEnable = lockValid & (code != SPD_QUAD);

endmodule

// File: rtl/spd_mode_detect_chk.sv
module spd_mode_detect_chk (
  input logic       mclk,
  input logic       rstN,
  input logic       autoMode,
  input logic [1:0] dfsBits,
  input logic [1:0] speedCode,
  input logic       lockValid,
  input logic       adcEnable
);

  a_r8_quad_blocks_adc: assert property (@(posedge mclk) disable iff (!rstN)
    (speedCode == 2'b10) |-> !adcEnable);

  a_r8_adc_needs_lock: assert property (@(posedge mclk) disable iff (!rstN)
    adcEnable |-> lockValid);

  a_r9_code_legal: assert property (@(posedge mclk) disable iff (!rstN)
    speedCode != 2'b11);

  a_r7_manual_follow: assert property (@(posedge mclk) disable iff (!rstN)
    (!autoMode && !$past(autoMode) && $past(dfsBits) != 2'b11)
      |-> (lockValid && speedCode == $past(dfsBits)));

  a_r7_manual_reserved: assert property (@(posedge mclk) disable iff (!rstN)
    (!autoMode && !$past(autoMode) && $past(dfsBits) == 2'b11)
      |-> (!lockValid && $stable(speedCode)));

  a_r6_hold_unlocked: assert property (@(posedge mclk) disable iff (!rstN)
    (autoMode && $past(autoMode) && !lockValid) |-> $stable(speedCode));

  a_r10_entry_unlock: assert property (@(posedge mclk) disable iff (!rstN)
    $rose(autoMode) |=> !lockValid);

endmodule

bind spd_mode_detect spd_mode_detect_chk u_chk (
  .mclk(mclk), .rstN(rstN), .autoMode(autoMode), .dfsBits(dfsBits),
  .speedCode(speedCode), .lockValid(lockValid), .adcEnable(adcEnable)
);

// File: tb/spd_mode_detect_tb.sv
module spd_mode_detect_tb;

  localparam int CLK_P = 10;

  logic       mclk = 1'b0;
  logic       rstN = 1'b0;
  logic       lrck = 1'b0;
  logic       autoMode = 1'b1;
  logic [1:0] dfsBits = 2'b00;
  logic [1:0] speedCode;
  logic       lockValid;
  logic       adcEnable;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #(CLK_P/2) mclk = ~mclk;

  spd_mode_detect u_dut (
    .mclk(mclk), .rstN(rstN), .lrck(lrck), .autoMode(autoMode),
    .dfsBits(dfsBits), .speedCode(speedCode), .lockValid(lockValid),
    .adcEnable(adcEnable)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkState(input string tag, input int code, input int lock, input int adc);
    chk({tag, " code"}, speedCode, code);
    chk({tag, " lock"}, lockValid, lock);
    chk({tag, " adc"}, adcEnable, adc);
  endtask

  task automatic frames(input int len, input int n);
    for (int k = 0; k < n; k++) begin
      lrck = 1'b1;
      repeat (len / 2) @(negedge mclk);
      lrck = 1'b0;
      repeat (len - len / 2) @(negedge mclk);
    end
  endtask

  task automatic t_reset();
    repeat (4) @(negedge mclk);
    rstN = 1'b1;
    repeat (2) @(negedge mclk);
    chkState("R9 reset", 0, 0, 0);
  endtask

  task automatic t_normal();
    frames(512, 3);
    chkState("R1 normal 512", 0, 1, 1);
  endtask

  task automatic t_agree();
    frames(256, 2);
    chkState("R5 single differing frame", 0, 0, 1 * 0);
    frames(256, 1);
    chkState("R2 double 256", 1, 1, 1);
  endtask

  task automatic t_quad();
    frames(128, 3);
    chkState("R3 quad 128 / R8 adc off", 2, 1, 0);
  endtask

  task automatic t_window();
    frames(512, 3);
    chkState("R1 back to normal", 0, 1, 1);
    frames(516, 3);
    chkState("R4 plus 4 accepted", 0, 1, 1);
    frames(508, 3);
    chkState("R4 minus 4 accepted", 0, 1, 1);
    frames(132, 3);
    chkState("R4 quad plus 4", 2, 1, 0);
    frames(517, 2);
    chkState("R4 plus 5 rejected", 2, 0, 0);
  endtask

  task automatic t_invalid();
    frames(256, 3);
    chkState("R2 double again", 1, 1, 1);
    frames(300, 2);
    chkState("R6 no match holds code", 1, 0, 0);
  endtask

  task automatic t_stall();
    frames(512, 3);
    chkState("R6 relock before stall", 0, 1, 1);
    repeat (4200) @(negedge mclk);
    chkState("R6 stopped frame clock", 0, 0, 0);
  endtask

  task automatic t_manual();
    autoMode = 1'b0;
    dfsBits  = 2'b10;
    repeat (2) @(negedge mclk);
    chkState("R7 manual quad", 2, 1, 0);
    dfsBits = 2'b01;
    repeat (2) @(negedge mclk);
    chkState("R7 manual double", 1, 1, 1);
    dfsBits = 2'b00;
    repeat (2) @(negedge mclk);
    chkState("R7 manual normal", 0, 1, 1);
    dfsBits = 2'b11;
    repeat (2) @(negedge mclk);
    chkState("R7 manual reserved", 0, 0, 0);
  endtask

  task automatic t_reentry();
    dfsBits = 2'b01;
    repeat (2) @(negedge mclk);
    chkState("R7 manual double before entry", 1, 1, 1);
    autoMode = 1'b1;
    @(negedge mclk);
    chkState("R10 entry drops lock", 1, 0, 0);
    frames(512, 2);
    chkState("R10 no lock from first boundary", 1, 0, 0);
    frames(512, 2);
    chkState("R10 relock normal", 0, 1, 1);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_agree();
    t_quad();
    t_window();
    t_invalid();
    t_stall();
    t_manual();
    t_reentry();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge mclk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule